// File: doc/BRIEF.md
# Pin Port with Event Capture and Interrupt

A general-purpose parallel pin port that sits on a small word-addressed register bus. Each of up to 32 pins can be turned into an output or left as an input. Software writes an output latch and a per-pin direction mask. It reads back the live pin levels. Input levels pass through a multi-flop synchronizer before anything else in the block uses them.

Pin events are noted in a sticky capture word, which software clears by writing ones. One interrupt line combines the pending events with a per-pin enable mask. The kind of event is fixed when the block is built and cannot be changed by software. The build choices are a rising transition, a falling transition, a transition in either direction, or a high level. In high-level builds there is no capture. The interrupt then follows the enabled, synchronized pin levels directly.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset all four registers read zero, every pin is an input (`pin_oe` zero), `pin_out` is zero and `irq` is low.
- R2: Direction bit 1 makes the pin an output. Direction bit 0 makes it an input. `pin_oe` equals the direction word one clock edge after it is written.
- R3: A write to the data word loads the output latch that drives `pin_out`. A data read returns the latch bit for output pins and the synchronized `pin_in` bit for input pins. An input change is visible in the data read two clock edges later.
- R4: Register bits at or above PIN_COUNT read as zero in every register, whatever was written to them.
- R5: Mask bit 1 enables the interrupt from that pin and mask bit 0 blocks it. With the mask word zero, `irq` stays low.
- R6: In rising builds (TRIGGER = TRIG_RISE), a 0-to-1 change of a synchronized input sets its capture bit, and a 1-to-0 change does not. The bit is set three clock edges after the `pin_in` change.
- R7: In falling builds (TRIG_FALL), only a 1-to-0 change sets the capture bit.
- R8: In either-edge builds (TRIG_BOTH), both kinds of change set the capture bit.
- R9: Writing a 1 to a capture bit clears it. Writing a 0 leaves it unchanged.
- R10: When an event for a bit arrives on the same clock edge as a clearing write to that bit, the bit stays set.
- R11: In edge builds, `irq` is high exactly when (capture AND mask) is nonzero.
- R12: In level builds (TRIG_LEVEL), `irq` is high exactly when (synchronized input AND mask) is nonzero, and the capture word always reads zero.
- R13: The word address `bus_addr` selects the register. 0 selects data (byte offset 0x0), 1 selects direction (0x4), 2 selects mask (0x8) and 3 selects capture (0xC). Reads are combinational and writes take effect on the clock edge where `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word address (byte offset bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | PIN_COUNT | Pin levels coming in from the pads |
| pin_out | output | PIN_COUNT | Output latch driven toward the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Register writes show on the next clock edge. A `pin_in` change reaches the data read and the level-mode interrupt after two clock edges. The same change reaches the capture word and the edge-mode interrupt after three. The bench therefore drives every stimulus just after a falling edge. After each pin change it waits three falling edges before it samples, and it reads registers at a falling edge after the committing rising edge. The same-edge clear race is set up by issuing the clearing write two falling edges after the pin change, so that the write commits on the edge where the event is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int BUS_W = 32;
   localparam int MAX_PINS = 32;

   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_BOTH  = 2'd2,
      TRIG_LEVEL = 2'd3
   } trig_e;

   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_DIR  = 2'd1;
   localparam logic [1:0] REG_MASK = 2'd2;
   localparam logic [1:0] REG_CAP  = 2'd3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_in;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   word_sel,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         case (word_sel)
            REG_DATA: out_q  <= wdata;
            REG_DIR:  dir_q  <= wdata;
            REG_MASK: mask_q <= wdata;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_event.sv
module gpio_event
   import gpio_irq_pkg::*;
#(
   parameter int    W       = 8,
   parameter trig_e TRIGGER = TRIG_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] clr,
   output logic [W-1:0] cap
);

   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] cap_q;

   if (TRIGGER == TRIG_RISE) begin : g_rise
      assign hit = lvl & ~prev_q;
   end else if (TRIGGER == TRIG_FALL) begin : g_fall
      assign hit = ~lvl & prev_q;
   end else if (TRIGGER == TRIG_BOTH) begin : g_both
      assign hit = lvl ^ prev_q;
   end else begin : g_level
      assign hit = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cap_q  <= '0;
      end else begin
         prev_q <= lvl;
         cap_q  <= (cap_q & ~clr) | hit;
      end
   end

   assign cap = cap_q;

   // R9: a set bit survives unless a clearing one was written for it
   p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(cap_q) & ~$past(clr)) & ~cap_q) == '0));

   if (TRIGGER != TRIG_LEVEL) begin : g_edge_chk
      // R10: a detected event always lands, even against a clear
      p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (($past(lvl ^ prev_q) & ~cap_q & $past(hit)) == '0));
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int    PIN_COUNT   = 32,
   parameter int    SYNC_STAGES = 2,
   parameter trig_e TRIGGER     = TRIG_RISE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [3:2]           bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic                 irq
);

   localparam int W = PIN_COUNT;

   if (PIN_COUNT < 1 || PIN_COUNT > MAX_PINS) begin : g_bad_width
      $error("gpio_irq_port: PIN_COUNT must lie in 1..32");
   end

   logic [W-1:0] sync_lvl;
   logic [W-1:0] out_q, dir_q, mask_q;
   logic [W-1:0] cap;
   logic [W-1:0] clr;
   logic [W-1:0] pin_view;
   logic [1:0]   word;
   logic         unused_wdata;

   assign word         = bus_addr;
   assign unused_wdata = ^bus_wdata;

   gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (sync_lvl)
   );

   gpio_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .word_sel (word),
      .wdata    (bus_wdata[W-1:0]),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .mask_q   (mask_q)
   );

   assign clr = (bus_wr && word == REG_CAP) ? bus_wdata[W-1:0] : '0;

   gpio_event #(.W(W), .TRIGGER(TRIGGER)) u_event (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_lvl),
      .clr   (clr),
      .cap   (cap)
   );

   assign pin_view = (dir_q & out_q) | (~dir_q & sync_lvl);
   assign pin_out  = out_q;
   assign pin_oe   = dir_q;

   always_comb begin
      bus_rdata = '0;
      case (word)
         REG_DATA: bus_rdata = BUS_W'(pin_view);
         REG_DIR:  bus_rdata = BUS_W'(dir_q);
         REG_MASK: bus_rdata = BUS_W'(mask_q);
         default:  bus_rdata = BUS_W'(cap);
      endcase
   end

   if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
      assign irq = |(sync_lvl & mask_q);
   end else begin : g_irq_edge
      assign irq = |(cap & mask_q);
   end

   // R5: a zero mask keeps the interrupt low
   p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   // R2: the output enables follow a direction write on the next edge
   p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && word == REG_DIR) |=> (pin_oe == $past(bus_wdata[W-1:0])));

   // R1: straight after reset the port is quiet
   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
   import gpio_irq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int NM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [NP-1:0] pin_in = '0;

   logic [31:0]   rd   [NM];
   logic [NP-1:0] pout [NM];
   logic [NP-1:0] poe  [NM];
   logic          irqv [NM];

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [NP-1:0] exp_cap [NM];
   logic [NP-1:0] cur_in = '0;
   logic [NP-1:0] dir_m = '0;
   logic [NP-1:0] out_m = '0;
   logic [NP-1:0] mask_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar m = 0; m < NM; m++) begin : g_mode
      gpio_irq_port #(.PIN_COUNT(NP), .SYNC_STAGES(2), .TRIGGER(trig_e'(m))) i_gpio_irq_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .bus_wr    (bus_wr),
         .bus_addr  (bus_addr),
         .bus_wdata (bus_wdata),
         .bus_rdata (rd[m]),
         .pin_in    (pin_in),
         .pin_out   (pout[m]),
         .pin_oe    (poe[m]),
         .irq       (irqv[m])
      );
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] edges(input int m, input logic [NP-1:0] o, input logic [NP-1:0] n);
      case (m)
         0: return n & ~o;
         1: return ~n & o;
         2: return n ^ o;
         default: return '0;
      endcase
   endfunction

   function automatic string cap_tag(input int m);
      case (m)
         0: return "R6";
         1: return "R7";
         2: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_word(input logic [1:0] a);
      bus_addr = a;
      #1;
   endtask

   task automatic set_pins(input logic [NP-1:0] nv);
      for (int m = 0; m < NM; m++) exp_cap[m] = exp_cap[m] | edges(m, cur_in, nv);
      pin_in = nv;
      cur_in = nv;
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_caps(input logic [NP-1:0] bits);
      wr(2'd3, 32'(bits));
      for (int m = 0; m < NM; m++) exp_cap[m] = exp_cap[m] & ~bits;
   endtask

   task automatic check_caps(input string force_tag);
      rd_word(2'd3);
      for (int m = 0; m < NM; m++)
         chk(force_tag == "" ? cap_tag(m) : force_tag, rd[m], 32'(exp_cap[m]));
   endtask

   task automatic check_irq();
      for (int m = 0; m < NM; m++) begin
         if (m == 3) chk("R12", 32'(irqv[m]), 32'(|(cur_in & mask_m)));
         else        chk("R11", 32'(irqv[m]), 32'(|(exp_cap[m] & mask_m)));
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      for (int m = 0; m < NM; m++) exp_cap[m] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd_word(2'(a));
         for (int m = 0; m < NM; m++) chk("R1", rd[m], 32'h0);
      end
      for (int m = 0; m < NM; m++) begin
         chk("R1", 32'(poe[m]), 32'h0);
         chk("R1", 32'(pout[m]), 32'h0);
         chk("R1", 32'(irqv[m]), 32'h0);
      end

      // R2 / R13 direction word at offset 0x4
      wr(2'd1, 32'h5);
      dir_m = 4'h5;
      chk("R2", 32'(poe[0]), 32'h5);
      rd_word(2'd1);
      chk("R13", rd[0], 32'h5);

      // R4 upper bits read zero
      wr(2'd1, 32'hFFFF_FFFF);
      rd_word(2'd1);
      chk("R4", rd[0], 32'h0000_000F);
      wr(2'd2, 32'hFFFF_FFF0);
      rd_word(2'd2);
      chk("R4", rd[0], 32'h0);
      wr(2'd0, 32'hFFFF_FFF0);
      chk("R4", 32'(pout[1]), 32'h0);
      wr(2'd1, 32'h5);

      // R3 data latch drives pin_out
      wr(2'd0, 32'h3);
      out_m = 4'h3;
      chk("R3", 32'(pout[2]), 32'h3);

      // R3 / R6-R8 / R12 / R5 sweep over every input pattern, mask zero
      mask_m = '0;
      wr(2'd2, 32'h0);
      for (int v = 0; v < 16; v++) begin
         set_pins(4'(v ^ (v >> 1)));
         rd_word(2'd0);
         chk("R3", rd[0], 32'((dir_m & out_m) | (~dir_m & cur_in)));
         check_caps("");
         for (int m = 0; m < NM; m++) chk("R5", 32'(irqv[m]), 32'h0);
      end
      for (int v = 15; v >= 0; v--) begin
         set_pins(4'(v));
         check_caps("");
      end

      // R3 two-edge latency on the data read, all pins inputs
      wr(2'd1, 32'h0);
      dir_m = '0;
      set_pins(4'h0);
      pin_in = 4'hA;
      for (int m = 0; m < NM; m++) exp_cap[m] = exp_cap[m] | edges(m, cur_in, 4'hA);
      cur_in = 4'hA;
      @(negedge clk);
      rd_word(2'd0);
      chk("R3", rd[0], 32'h0);
      @(negedge clk);
      rd_word(2'd0);
      chk("R3", rd[0], 32'hA);
      @(negedge clk);
      check_caps("");

      // R5 / R11 / R12 with full mask
      wr(2'd2, 32'hF);
      mask_m = 4'hF;
      rd_word(2'd2);
      chk("R5", rd[0], 32'hF);
      check_irq();

      // R9 write-one-to-clear
      set_pins(4'hF);
      set_pins(4'h0);
      check_caps("R9");
      clear_caps(4'h5);
      check_caps("R9");
      clear_caps(4'h0);
      check_caps("R9");
      check_irq();

      // R11 mask excludes the pending bits
      wr(2'd2, 32'h5);
      mask_m = 4'h5;
      check_irq();
      clear_caps(4'hF);
      check_irq();

      // R10 event and clear on the same edge, rising then falling
      wr(2'd2, 32'hF);
      mask_m = 4'hF;
      pin_in = 4'h1;
      repeat (2) @(negedge clk);
      wr(2'd3, 32'hF);
      for (int m = 0; m < NM; m++) exp_cap[m] = (exp_cap[m] & ~4'hF) | edges(m, cur_in, 4'h1);
      cur_in = 4'h1;
      check_caps("R10");
      check_irq();
      clear_caps(4'hF);
      pin_in = 4'h0;
      repeat (2) @(negedge clk);
      wr(2'd3, 32'hF);
      for (int m = 0; m < NM; m++) exp_cap[m] = (exp_cap[m] & ~4'hF) | edges(m, cur_in, 4'h0);
      cur_in = 4'h0;
      check_caps("R10");

      // R12 level mode follows enabled input
      wr(2'd2, 32'h2);
      mask_m = 4'h2;
      set_pins(4'h1);
      check_irq();
      set_pins(4'h2);
      check_irq();
      check_caps("");
      set_pins(4'h0);
      check_irq();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule